// File: doc/BRIEF.md
# Diagonally Pipelined Unsigned Array Multiplier

This block multiplies two unsigned `W`-bit operands and returns the full `2W`-bit product. It is built from a square array of cells. Each cell ANDs one bit of each operand and adds that bit to a running sum with a full adder. Sums move down the array from row to row, and carries move left along a row.

Every cell has its own output register. Cell (row `i`, column `j`) sits in pipeline slot `2i+j`, so each register cut follows a diagonal slice of the array. As a result, every input of a cell comes from a register exactly one slot earlier. No path crosses more than one full adder between registers, whatever the width.

Operand bits pass through per-bit delay chains so that they reach the cell that needs them in the right slot. Product bits that finish early are held back so that all `2W` bits leave together. A valid flag travels alongside the data with the same delay. A new operand pair may be accepted on every clock.

Top module: `diag_pipe_mult`

## Requirements
- R1: While `rst_n` is low, and after release until the first accepted pair has had time to travel through the pipeline, `out_valid` stays 0.
- R2: Each result carried on `prod` equals the unsigned product `a*b` of the pair it belongs to, and never exceeds `(2^W-1)^2`.
- R3: A pair sampled with `in_valid` high at rising edge k appears with `out_valid` high immediately after rising edge k+3W-3, and never earlier.
- R4: Pairs presented on consecutive clocks produce results on consecutive clocks, so throughput is one product per cycle.
- R5: A cycle with `in_valid` low yields a cycle with `out_valid` low exactly 3W-3 edges later, so gaps in the input stream are reproduced in the output stream.
- R6: Every accepted pair yields exactly one result, in acceptance order, and no result appears without an accepted pair.
- R7: The extreme operands are handled correctly: a zero operand gives 0, and two all-ones operands give `2^(2W) - 2^(W+1) + 1`, which sets the top product bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Qualifies `a` and `b` in this cycle |
| a | input | W | Unsigned multiplicand |
| b | input | W | Unsigned multiplier |
| out_valid | output | 1 | Qualifies `prod` in this cycle |
| prod | output | 2W | Unsigned product |

## Verification
The hardest situation to reach from the ports is a stream in which results finishing at different diagonal slots from neighbouring pairs share the pipeline. The same stream must also include idle slots, since a mis-timed delay chain only shows up when adjacent pairs differ. The stimulus therefore first sweeps every one of the 256 pairs of the 4-bit configuration back to back, so that each pair is followed immediately by a different one. It then runs a pseudo-random stream with irregular bubbles. Every result is matched against a reference queue, both for its value and for the exact cycle it is due.

// File: rtl/diag_pipe_mult.sv
module diag_pipe_mult #(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic           out_valid,
  output logic [2*W-1:0] prod
);
  localparam int TLAST = 3*W-4;
  localparam int LAT   = 3*W-3;

  function automatic int ts_of(input int k);
    if (k == 0)          return 0;
    else if (k <= W-2)   return 2*k-1;
    else if (k <= 2*W-2) return W-2+k;
    else                 return TLAST;
  endfunction

  for (genvar j = 0; j < W; j++) begin : ga
    localparam int LEN = 2*W+j-3;
    logic d [LEN];
    always_ff @(posedge clk) begin
      d[0] <= a[j];
      for (int t = 1; t < LEN; t++) d[t] <= d[t-1];
    end
  end

  for (genvar i = 0; i < W; i++) begin : gb
    localparam int LEN = (i == 0) ? W-1 : 2*i+W-2;
    logic d [LEN];
    always_ff @(posedge clk) begin
      d[0] <= b[i];
      for (int t = 1; t < LEN; t++) d[t] <= d[t-1];
    end
  end

  for (genvar i = 1; i < W; i++) begin : rw
    if (i >= 2) begin : cd
      logic cp;
      always_ff @(posedge clk) cp <= rw[i-1].cl[W-1].c_q;
    end
    for (genvar j = 0; j < W; j++) begin : cl
      logic x, y, ci, s_q, c_q;
      assign x = ga[j].d[2*i+j-2] & gb[i].d[2*i+j-2];
      if (i == 1) begin : g_y
        if (j < W-1) begin : g_pp
          assign y = ga[j+1].d[j] & gb[0].d[j];
        end else begin : g_z
          assign y = 1'b0;
        end
      end else begin : g_y
        if (j < W-1) begin : g_s
          assign y = rw[i-1].cl[j+1].s_q;
        end else begin : g_c
          assign y = rw[i].cd.cp;
        end
      end
      if (j == 0) begin : g_ci
        assign ci = 1'b0;
      end else begin : g_ci
        assign ci = rw[i].cl[j-1].c_q;
      end
      always_ff @(posedge clk) begin
        s_q <= x ^ y ^ ci;
        c_q <= (x & y) | (ci & (x ^ y));
      end
    end
  end

  logic [2*W-1:0] src;
  for (genvar k = 0; k < 2*W; k++) begin : gs
    if (k == 0) begin : g0
      assign src[k] = ga[0].d[0] & gb[0].d[0];
    end else if (k <= W-2) begin : g1
      assign src[k] = rw[k].cl[0].s_q;
    end else if (k <= 2*W-2) begin : g2
      assign src[k] = rw[W-1].cl[k-W+1].s_q;
    end else begin : g3
      assign src[k] = rw[W-1].cl[W-1].c_q;
    end
  end

  logic [2*W-1:0] al [0:TLAST];
  logic [2*W-1:0] dl [1:TLAST];

  always_comb begin
    al[0] = '0;
    al[0][0] = src[0];
    for (int t = 1; t <= TLAST; t++)
      for (int k = 0; k < 2*W; k++)
        al[t][k] = (ts_of(k) == t) ? src[k] : dl[t][k];
  end

  always_ff @(posedge clk) begin
    for (int t = 1; t <= TLAST; t++) dl[t] <= al[t-1];
    prod <= al[TLAST];
  end

  logic [0:LAT] vp;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vp <= '0;
    else        vp <= {in_valid, vp[0:LAT-1]};
  end
  assign out_valid = vp[LAT];
endmodule

module diag_pipe_mult_chk #(
  parameter int W = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           out_valid,
  input logic [2*W-1:0] prod
);
  localparam int LAT = 3*W-3;
  localparam logic [2*W-1:0] MAXP = (2*W)'(((2**W)-1) * ((2**W)-1));

  int unsigned nin, nout, since;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nin <= 0; nout <= 0; since <= 0;
    end else begin
      if (in_valid)  nin  <= nin + 1;
      if (out_valid) nout <= nout + 1;
      if (since <= LAT) since <= since + 1;
    end
  end

  AST_IDLE_IN_RESET: assert property (@(posedge clk) !rst_n |-> !out_valid); // R1
  AST_NO_EARLY_RESULT: assert property (@(posedge clk) disable iff (!rst_n) (since <= LAT) |-> !out_valid); // R3
  AST_RESULT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (nin > nout)); // R6
  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (nin - nout) <= LAT+1); // R6
  AST_PROD_RANGE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (prod <= MAXP)); // R2
endmodule

bind diag_pipe_mult diag_pipe_mult_chk #(.W(W)) u_chk (.*);

// File: tb/sim_diag_pipe_mult.sv
module sim_diag_pipe_mult;
  localparam int W = 4;
  localparam int LAT = 3*W-3;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [W-1:0] a = '0, b = '0;
  logic out_valid;
  logic [2*W-1:0] prod;

  diag_pipe_mult #(.W(W)) u0 (.*);

  always #5 clk = ~clk;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    int e;
    string req;
  } item_t;

  item_t q[$];
  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] lf = 16'hACE1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_out();
    item_t it;
    logic [2*W-1:0] ex;
    if (out_valid) begin
      if (q.size() == 0) begin
        chk(0, "R6", "result without accepted pair", 1, 0);
      end else if (cyc < q[0].e + LAT) begin
        chk(0, "R5", "result in a bubble slot", cyc, q[0].e + LAT);
      end else begin
        it = q.pop_front();
        ex = (2*W)'(it.a) * (2*W)'(it.b);
        chk(prod == ex, it.req, "product value", prod, ex);
        chk(cyc == it.e + LAT, "R3", "result cycle", cyc, it.e + LAT);
      end
    end else if (q.size() > 0 && cyc >= q[0].e + LAT) begin
      it = q.pop_front();
      chk(0, "R3", "result missing at due cycle", 0, 1);
    end
  endtask

  task automatic step(input bit v, input logic [W-1:0] x, input logic [W-1:0] y,
                      input string req);
    @(negedge clk);
    check_out();
    in_valid = v; a = x; b = y;
    if (v) q.push_back('{x, y, cyc + 1, req});
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
    end
    rst_n = 1;
    repeat (5) begin
      @(negedge clk);
      chk(out_valid == 0, "R1", "out_valid idle after reset", out_valid, 0);
    end
    // R2 R4 R7: exhaustive back-to-back sweep
    for (int x = 0; x < 2**W; x++)
      for (int y = 0; y < 2**W; y++)
        step(1, W'(x), W'(y),
             (x == 0 || y == 0 || (x == 2**W-1 && y == 2**W-1)) ? "R7" : "R4");
    // R2: a few fixed patterns after an idle gap
    step(0, '0, '0, "R2");
    step(1, W'(5), W'(11), "R2");
    step(1, W'(9), W'(6), "R2");
    step(0, '0, '0, "R2");
    step(1, W'(15), W'(15), "R7");
    // R5: pseudo-random stream with bubbles
    for (int n = 0; n < 400; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[3] | lf[7], lf[11:8], lf[15:12], "R5");
    end
    repeat (LAT + 4) step(0, '0, '0, "R5");
    chk(q.size() == 0, "R6", "pairs left without result", q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R6 watchdog expired: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule